// File: doc/BRIEF.md
# Dual Stepper Motor Phase Sequencer

This block produces the four winding phases for two four-phase stepper motors, one moving the print carriage and one feeding paper. A CPU reaches it over a small 8-bit register bus: one mode register and one phase register per motor. Each motor is either stepped by hardware or driven by firmware. When stepped by hardware, every rising edge on that motor's step input moves the winding pattern one full step with two phases on. The rotation sense comes from a direction bit. When driven by firmware, the CPU writes the winding pattern itself and the step input is ignored.

The phase registers read back their live value, so firmware can see where a hardware-stepped motor has stopped. Writing a phase register while the motor is hardware-stepped sets the point from which the next step moves. Two bits of the mode register drive two bank-select outputs for the surrounding memory map.

Top module: `dual_stepper_seq`

## Requirements
- R1: After a synchronous active-high reset, bank_sel is 00, both motors are hardware-stepped with direction 0, and both phase outputs are 4'b1010 (A and B on).
- R2: Phase register layout is bit 3 = A, bit 2 = C, bit 1 = B, bit 0 = D. A read with bus_rd high returns the carriage phase register at address 5 and the paper feed phase register at address 4, with bits 7:4 zero. Every other address, including the write-only mode register at address 0, reads as zero.
- R3: A write to address 0 loads the mode register. Bit 6 drives bank_sel[1] and bit 5 drives bank_sel[0]. Bit 4 is the carriage direction and bit 3 selects carriage manual mode (0 = hardware stepping). Bit 2 is the paper feed direction and bit 1 selects paper feed manual mode. The remaining bits are not stored.
- R4: With direction 0 (forward) in hardware-stepped mode, each step moves the pattern 1010 -> 0110 -> 0101 -> 1001 -> 1010.
- R5: With direction 1, each step moves through the same four patterns in the opposite order: 1010 -> 1001 -> 0101 -> 0110 -> 1010.
- R6: The step input is synchronized. A rising edge changes the phase output at the third rising clock edge after the input rises. A level held high causes no further step, and a falling edge causes none.
- R7: In manual mode the step input has no effect. A phase register write appears on the phase output after the clock edge that samples bus_wr.
- R8: In hardware-stepped mode, a phase register write replaces the current pattern, and the next step moves on from the written value. If a write and a step fall on the same edge, the write wins.
- R9: A step taken from a pattern outside the four-step cycle lands on 1010 in either direction.
- R10: The two motors are independent. A step or write for one motor leaves the other motor's phase output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when bus_rd is low |
| carr_step | input | 1 | Carriage step clock, asynchronous |
| feed_step | input | 1 | Paper feed step clock, asynchronous |
| carr_phase | output | 4 | Carriage winding phases {A,C,B,D} |
| feed_phase | output | 4 | Paper feed winding phases {A,C,B,D} |
| bank_sel | output | 2 | Bank select outputs from mode bits 6:5 |

## Verification
The hardest case to reach is a firmware write to a phase register on the same clock edge that a synchronized step is applied. The step passes through a synchronizer, so the write must be placed exactly two edges after the step input rises. A directed sequence times the rising step input and the write strobe against the known synchronizer latency to get there. Random sequences of mode writes, phase writes and step pulses on either motor then cover direction changes, out-of-cycle start patterns and cross-motor independence.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

    localparam int NUM_MOTORS = 2;
    localparam int DATA_W     = 8;
    localparam int PH_W       = 4;

    typedef logic [PH_W-1:0] phase_t;

    // bit 3 = A, bit 2 = C, bit 1 = B, bit 0 = D
    localparam phase_t PH_AB = 4'b1010;
    localparam phase_t PH_BC = 4'b0110;
    localparam phase_t PH_CD = 4'b0101;
    localparam phase_t PH_DA = 4'b1001;

    localparam int MODE_ADDR = 0;

    typedef struct packed {
        logic [1:0] bank;
        logic       carr_rev;
        logic       carr_man;
        logic       feed_rev;
        logic       feed_man;
    } mode_t;

    // motor 0 = carriage, motor 1 = paper feed
    function automatic int phase_addr(int motor);
        return (motor == 0) ? 5 : 4;
    endfunction

    function automatic phase_t step_next(phase_t cur, logic rev);
        phase_t nxt;
        case (cur)
            PH_AB:   nxt = rev ? PH_DA : PH_BC;
            PH_BC:   nxt = rev ? PH_AB : PH_CD;
            PH_CD:   nxt = rev ? PH_BC : PH_DA;
            PH_DA:   nxt = rev ? PH_CD : PH_AB;
            default: nxt = PH_AB;
        endcase
        return nxt;
    endfunction

    function automatic mode_t mode_from_bus(logic [DATA_W-1:0] d);
        mode_t m;
        m.bank     = d[6:5];
        m.carr_rev = d[4];
        m.carr_man = d[3];
        m.feed_rev = d[2];
        m.feed_man = d[1];
        return m;
    endfunction

endpackage

// File: rtl/step_sync.sv
module step_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic step_in,
    output logic step_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], step_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign step_pulse = sync_q[STAGES-1] & ~prev_q;

    // R6: one edge gives a one-cycle pulse
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        step_pulse |=> !step_pulse);

endmodule

// File: rtl/phase_channel.sv
module phase_channel
    import stepper_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  phase_t wr_phase,
    input  logic   step_pulse,
    input  logic   manual,
    input  logic   reverse,
    output phase_t phase
);
    phase_t phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_AB;
        end else if (wr_en) begin
            phase_q <= wr_phase;
        end else if (step_pulse && !manual) begin
            phase_q <= step_next(phase_q, reverse);
        end
    end

    assign phase = phase_q;

    // R7: steps are ignored in manual mode
    p_manual_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (manual && !wr_en) |=> $stable(phase));

    // R8: a write wins and lands on the next edge
    p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (phase == $past(wr_phase)));

    // R4: every automatic step leaves exactly two windings on
    p_two_on_r4: assert property (@(posedge clk) disable iff (rst)
        (!manual && step_pulse && !wr_en) |=> ($countones(phase) == 2));

    // R10: no change without a write or a step
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !step_pulse) |=> $stable(phase));

endmodule

// File: rtl/dual_stepper_seq.sv
module dual_stepper_seq
    import stepper_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              carr_step,
    input  logic              feed_step,
    output logic [PH_W-1:0]   carr_phase,
    output logic [PH_W-1:0]   feed_phase,
    output logic [1:0]        bank_sel
);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);

    mode_t  mode_q;
    logic   mode_wr;
    logic   step_raw [NUM_MOTORS];
    logic   man      [NUM_MOTORS];
    logic   rev      [NUM_MOTORS];
    phase_t ph       [NUM_MOTORS];
    logic   ph_hit   [NUM_MOTORS];

    assign mode_wr = bus_wr && (bus_addr == MODE_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q <= mode_from_bus(bus_wdata);
        end
    end

    assign step_raw[0] = carr_step;
    assign step_raw[1] = feed_step;
    assign man[0]      = mode_q.carr_man;
    assign man[1]      = mode_q.feed_man;
    assign rev[0]      = mode_q.carr_rev;
    assign rev[1]      = mode_q.feed_rev;

    for (genvar m = 0; m < NUM_MOTORS; m++) begin : g_motor
        localparam logic [ADDR_W-1:0] PH_A = ADDR_W'(phase_addr(m));
        logic pulse;

        assign ph_hit[m] = (bus_addr == PH_A);

        step_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk        (clk),
            .rst        (rst),
            .step_in    (step_raw[m]),
            .step_pulse (pulse)
        );

        phase_channel u_chan (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (bus_wr && ph_hit[m]),
            .wr_phase   (bus_wdata[PH_W-1:0]),
            .step_pulse (pulse),
            .manual     (man[m]),
            .reverse    (rev[m]),
            .phase      (ph[m])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            for (int m = 0; m < NUM_MOTORS; m++) begin
                if (ph_hit[m]) bus_rdata = {{(DATA_W-PH_W){1'b0}}, ph[m]};
            end
        end
    end

    assign carr_phase = ph[0];
    assign feed_phase = ph[1];
    assign bank_sel   = mode_q.bank;

    // R2: upper read bits are always zero
    p_rd_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:PH_W] == '0);

    // R3: bank outputs only move on a mode write
    p_bank_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !mode_wr |=> $stable(bank_sel));

    // R3: bank outputs follow the written bits
    p_bank_load_r3: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (bank_sel == $past(bus_wdata[6:5])));

endmodule

// File: tb/dual_stepper_seq_tb.sv
module dual_stepper_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] bus_addr;
    logic       bus_rd, bus_wr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       carr_step, feed_step;
    logic [3:0] carr_phase, feed_phase;
    logic [1:0] bank_sel;

    int checks = 0;
    int errors = 0;

    logic [3:0] exp_ph [2];
    logic       exp_man [2];
    logic       exp_rev [2];
    logic [1:0] exp_bank;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_stepper_seq dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .carr_step(carr_step), .feed_step(feed_step),
        .carr_phase(carr_phase), .feed_phase(feed_phase), .bank_sel(bank_sel)
    );

    function automatic logic [3:0] model_next(logic [3:0] cur, logic rev);
        logic [3:0] ring [4];
        ring[0] = 4'b1010; ring[1] = 4'b0110; ring[2] = 4'b0101; ring[3] = 4'b1001;
        for (int i = 0; i < 4; i++) begin
            if (ring[i] == cur) return rev ? ring[(i + 3) % 4] : ring[(i + 1) % 4];
        end
        return 4'b1010;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        check({tag, " carr_phase"}, {4'h0, carr_phase}, {4'h0, exp_ph[0]});
        check({tag, " feed_phase"}, {4'h0, feed_phase}, {4'h0, exp_ph[1]});
        check({tag, " bank_sel"}, {6'h0, bank_sel}, {6'h0, exp_bank});
    endtask

    task automatic bus_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 3'd0) begin
            exp_bank   = d[6:5];
            exp_rev[0] = d[4]; exp_man[0] = d[3];
            exp_rev[1] = d[2]; exp_man[1] = d[1];
        end else if (a == 3'd5) exp_ph[0] = d[3:0];
        else if (a == 3'd4) exp_ph[1] = d[3:0];
    endtask

    task automatic bus_read_check(string tag, logic [2:0] a);
        logic [7:0] e;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        e = (a == 3'd5) ? {4'h0, exp_ph[0]} : (a == 3'd4) ? {4'h0, exp_ph[1]} : 8'h00;
        check(tag, bus_rdata, e);
        bus_rd = 1'b0;
    endtask

    task automatic set_step(int m, logic v);
        if (m == 0) carr_step = v; else feed_step = v;
    endtask

    task automatic pulse_step(int m);
        @(negedge clk);
        set_step(m, 1'b1);
        repeat (4) @(negedge clk);
        set_step(m, 1'b0);
        repeat (4) @(negedge clk);
        if (!exp_man[m]) exp_ph[m] = model_next(exp_ph[m], exp_rev[m]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
        carr_step = 0; feed_step = 0;
        exp_ph[0] = 4'b1010; exp_ph[1] = 4'b1010;
        exp_man[0] = 0; exp_man[1] = 0; exp_rev[0] = 0; exp_rev[1] = 0;
        exp_bank = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_outputs("R1 reset");
        bus_read_check("R2 read carriage", 3'd5);
        bus_read_check("R2 read feed", 3'd4);
        bus_read_check("R2 mode address reads zero", 3'd0);

        // R4 forward cycle on carriage, R10 feed untouched
        for (int i = 0; i < 4; i++) begin
            pulse_step(0);
            check_outputs("R4 forward step");
        end
        // R5 reverse on feed
        bus_write(3'd0, 8'b0000_0100);
        for (int i = 0; i < 4; i++) begin
            pulse_step(1);
            check_outputs("R5 reverse step");
        end
        check_outputs("R10 carriage unchanged");

        // R6 latency: change at third edge after rise
        bus_write(3'd0, 8'h00);
        @(negedge clk);
        carr_step = 1'b1;
        @(posedge clk); @(posedge clk);
        #1 check("R6 no step before third edge", {4'h0, carr_phase}, {4'h0, exp_ph[0]});
        @(posedge clk);
        #1 exp_ph[0] = model_next(exp_ph[0], 1'b0);
        check("R6 step at third edge", {4'h0, carr_phase}, {4'h0, exp_ph[0]});
        repeat (10) @(negedge clk);
        check("R6 held high one step", {4'h0, carr_phase}, {4'h0, exp_ph[0]});
        carr_step = 1'b0;
        repeat (6) @(negedge clk);
        check("R6 falling edge no step", {4'h0, carr_phase}, {4'h0, exp_ph[0]});

        // R7 manual mode ignores steps; write applies
        bus_write(3'd0, 8'b0000_1010);
        pulse_step(0);
        pulse_step(1);
        check_outputs("R7 manual ignores step");
        bus_write(3'd5, 8'hF3);
        check_outputs("R7 manual write");
        bus_read_check("R2 upper bits zero", 3'd5);

        // R8 auto write then step from it
        bus_write(3'd0, 8'h00);
        bus_write(3'd5, 8'h05);
        pulse_step(0);
        check_outputs("R8 step from written start");

        // R8 write collides with step pulse
        @(negedge clk);
        carr_step = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = 3'd5; bus_wdata = 8'h06; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; exp_ph[0] = 4'b0110;
        check("R8 write wins over step", {4'h0, carr_phase}, 8'h06);
        carr_step = 1'b0;
        repeat (6) @(negedge clk);

        // R9 out-of-cycle patterns
        bus_write(3'd4, 8'h0F);
        bus_write(3'd0, 8'b0000_0100);
        pulse_step(1);
        check("R9 invalid to 1010", {4'h0, feed_phase}, 8'h0A);

        // R3 bank bits
        bus_write(3'd0, 8'b0100_0000);
        check_outputs("R3 bank bit6");
        bus_write(3'd0, 8'b0010_0000);
        check_outputs("R3 bank bit5");

        // random mix
        for (int n = 0; n < 300; n++) begin
            int op = $urandom_range(0, 5);
            case (op)
                0: bus_write(3'd0, 8'($urandom()));
                1: bus_write(3'd5, 8'($urandom()));
                2: bus_write(3'd4, 8'($urandom()));
                3: pulse_step(0);
                4: pulse_step(1);
                default: bus_read_check("R2 random read", 3'($urandom()));
            endcase
            check_outputs("R10 random mix");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule